// File: doc/BRIEF.md
# Integer to double-precision converter

This block turns a signed two's-complement integer into an IEEE-754 binary64 value. Each operation chooses between a 32-bit and a 64-bit source. A 32-bit source is taken from the low 32 bits of the source bus and sign-extended, so bits 63:32 of the bus are ignored. The result replaces the low 64 bits of a 128-bit destination word. The high 64 bits come from the prior destination value supplied with the operation and pass through unchanged.

A 2-bit rounding field, sampled with each operation, sets how a result that cannot be represented exactly is rounded. An inexact flag goes with every result. The datapath is one registered stage: an operation presented with its valid strobe comes out on the following clock. The block is meant for the back end of a scalar conversion unit. Operand fetch and exception handling stay outside it.

Top module: `int2dbl_conv`

## Requirements
- R1: `out_vld` is high exactly one clock after a cycle with `in_vld` high, and low otherwise. Reset (`rst_n` low) forces `out_vld` low.
- R2: When `in_is64` is 0, the source is `in_src[31:0]` sign-extended to 64 bits and `in_src[63:32]` is ignored. Every such result is exact, so `out_inexact` is 0.
- R3: When `in_is64` is 1, `in_src` is the 64-bit source. A representable value converts exactly, with sign bit 63 equal to the source sign, exponent field (bits 62:52) equal to 1023 plus the position of the magnitude's leading one, and fraction bits 51:0 equal to the magnitude bits below that leading one.
- R4: `out_dst[127:64]` equals `in_dst[127:64]` of the same operation.
- R5: A zero source gives `out_dst[63:0]` = 0 (+0.0) and `out_inexact` = 0 under every rounding mode.
- R6: The source -2^63 gives 0xC3E0000000000000 exactly, with exponent field 1086 and a zero fraction.
- R7: `in_rmode` = 2'b00 rounds to nearest, and a tie goes to the even significand.
- R8: `in_rmode` = 2'b01 rounds toward negative infinity.
- R9: `in_rmode` = 2'b10 rounds toward positive infinity.
- R10: `in_rmode` = 2'b11 rounds toward zero, which truncates the magnitude.
- R11: `out_inexact` is 1 exactly when any magnitude bit below the 53 kept bits is nonzero.
- R12: A rounding carry out of the 53-bit significand adds one to the exponent and clears the fraction. For example, 2^63-1 rounded to nearest gives 0x43E0000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation valid |
| in_is64 | input | 1 | 1: 64-bit source, 0: 32-bit source in bits 31:0 |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| in_src | input | 64 | Signed integer source |
| in_dst | input | 128 | Prior destination value |
| out_vld | output | 1 | Result valid |
| out_dst | output | 128 | Merged destination: converted value in 63:0 |
| out_inexact | output | 1 | Result was rounded |

## Verification
A fault in this block shows up at the ports on the clock that follows the operation that exposed it, because nothing carries over between operations. A wrong leading-zero count gives a wrong exponent together with a shifted fraction. A wrong guard or sticky extraction shows up in the last fraction bit and in the inexact flag, and only for sources above 2^53. Carry handling is seen only where the significand is all ones. For that reason the stimulus includes values near 2^53 and near 2^63, the extreme negative value, and ties under each of the four modes.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_TRUNC   = 2'b11
  } rmode_e;

  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
endpackage

// File: rtl/i2d_lzc.sv
module i2d_lzc #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  always_comb begin
    cnt      = CW'(W);
    all_zero = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        cnt      = CW'(W - 1 - i);
        all_zero = 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2d_rounder.sv
module i2d_rounder
  import i2d_pkg::*;
#(
  parameter int unsigned SIG_W = 53
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             grd,
  input  logic             rnd,
  input  logic             stk,
  input  logic             neg,
  input  rmode_e           rmode,
  output logic [SIG_W-2:0] frac,
  output logic             carry,
  output logic             inexact
);
  logic           inc;
  logic [SIG_W:0] sum;

  always_comb begin
    inexact = grd | rnd | stk;
    unique case (rmode)
      RM_NEAREST: inc = grd & (rnd | stk | sig[0]);
      RM_DOWN:    inc = neg & inexact;
      RM_UP:      inc = ~neg & inexact;
      default:    inc = 1'b0;
    endcase
    sum   = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
    carry = sum[SIG_W];
    frac  = carry ? '0 : sum[SIG_W-2:0];
  end
endmodule

// File: rtl/int2dbl_conv.sv
module int2dbl_conv
  import i2d_pkg::*;
#(
  parameter int unsigned SRC_W    = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned DST_W    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_is64,
  input  logic [1:0]       in_rmode,
  input  logic [SRC_W-1:0] in_src,
  input  logic [DST_W-1:0] in_dst,
  output logic             out_vld,
  output logic [DST_W-1:0] out_dst,
  output logic             out_inexact
);
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned DROP  = SRC_W - SIG_W;
  localparam int unsigned CW    = $clog2(SRC_W) + 1;
  localparam int unsigned RES_W = 1 + EXP_W + FRAC_W;

  logic [SRC_W-1:0]  sext;
  logic              neg;
  logic [SRC_W-1:0]  mag;
  logic [CW-1:0]     lz;
  logic              mag_zero;
  logic [SRC_W-1:0]  norm;
  logic [SIG_W-1:0]  sig;
  logic              grd, rnd, stk;
  logic [FRAC_W-1:0] frac_r;
  logic              carry;
  logic              inx_r;
  logic [EXP_W-1:0]  exp_base;
  logic [EXP_W-1:0]  exp_fin;
  logic [RES_W-1:0]  res_d;
  logic              inx_d;
  logic [DST_W-1:0]  dst_d;

  logic              vld_q;
  logic [DST_W-1:0]  dst_q;
  logic              inx_q;

  // source widening and magnitude
  always_comb begin
    sext = in_is64 ? in_src
                   : {{(SRC_W-NARROW_W){in_src[NARROW_W-1]}}, in_src[NARROW_W-1:0]};
    neg  = sext[SRC_W-1];
    mag  = neg ? (~sext + 1'b1) : sext;
  end

  i2d_lzc #(.W(SRC_W)) u_lzc (
    .vec      (mag),
    .cnt      (lz),
    .all_zero (mag_zero)
  );

  always_comb begin
    norm     = mag << lz;
    exp_base = EXP_W'(BIAS + SRC_W - 1) - EXP_W'(lz);
  end

  assign sig = norm[SRC_W-1 -: SIG_W];

  generate
    if (DROP >= 3) begin : g_grs
      assign grd = norm[DROP-1];
      assign rnd = norm[DROP-2];
      assign stk = |norm[DROP-3:0];
    end else if (DROP == 2) begin : g_gr
      assign grd = norm[1];
      assign rnd = norm[0];
      assign stk = 1'b0;
    end else begin : g_none
      assign grd = 1'b0;
      assign rnd = 1'b0;
      assign stk = 1'b0;
    end
  endgenerate

  i2d_rounder #(.SIG_W(SIG_W)) u_rnd (
    .sig     (sig),
    .grd     (grd),
    .rnd     (rnd),
    .stk     (stk),
    .neg     (neg),
    .rmode   (rmode_e'(in_rmode)),
    .frac    (frac_r),
    .carry   (carry),
    .inexact (inx_r)
  );

  // next-state: pack and merge
  always_comb begin
    exp_fin = exp_base + {{(EXP_W-1){1'b0}}, carry};
    if (mag_zero) begin
      res_d = '0;
      inx_d = 1'b0;
    end else begin
      res_d = {neg, exp_fin, frac_r};
      inx_d = inx_r;
    end
    dst_d = {in_dst[DST_W-1:RES_W], res_d};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      dst_q <= dst_d;
      inx_q <= inx_d;
    end
  end

  assign out_vld     = vld_q;
  assign out_dst     = dst_q;
  assign out_inexact = inx_q;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);  // R1
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);  // R1
  AST_NARROW_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_is64) |=> !out_inexact);  // R2
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_is64) |=> (out_dst[RES_W-1] == $past(in_src[SRC_W-1])));  // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_dst[DST_W-1:RES_W] == $past(in_dst[DST_W-1:RES_W])));  // R4
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_is64 && in_src == '0) |=> (out_dst[RES_W-1:0] == '0 && !out_inexact));  // R5
endmodule

// File: tb/sim_int2dbl_conv.sv
module sim_int2dbl_conv;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [127:0] dst;
    logic         inx;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic         in_is64;
  logic [1:0]   in_rmode;
  logic [63:0]  in_src;
  logic [127:0] in_dst;
  logic         out_vld;
  logic [127:0] out_dst;
  logic         out_inexact;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int2dbl_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_is64(in_is64),
    .in_rmode(in_rmode), .in_src(in_src), .in_dst(in_dst),
    .out_vld(out_vld), .out_dst(out_dst), .out_inexact(out_inexact)
  );

  // independent reference: {inexact, result}
  function automatic logic [64:0] ref_conv(input logic [63:0] src, input logic is64,
                                           input logic [1:0] rm);
    logic [63:0] sx, mag, kept, rem, half;
    logic        ng, up, inx;
    int          p, sh, ex;
    sx  = is64 ? src : {{32{src[31]}}, src[31:0]};
    ng  = sx[63];
    mag = ng ? (64'd0 - sx) : sx;
    if (mag == 64'd0) return 65'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    ex  = 1023 + p;
    inx = 1'b0;
    if (p <= 52) begin
      kept = mag << (52 - p);
    end else begin
      sh   = p - 52;
      kept = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 64'd0);
      case (rm)
        2'b00:   up = (rem > half) || ((rem == half) && kept[0]);
        2'b01:   up = ng && inx;
        2'b10:   up = !ng && inx;
        default: up = 1'b0;
      endcase
      kept = kept + {63'd0, up};
      if (kept[53]) begin
        ex   = ex + 1;
        kept = kept >> 1;
      end
    end
    return {inx, ng, ex[10:0], kept[51:0]};
  endfunction

  task automatic send(input logic [63:0] src, input logic is64, input logic [1:0] rm,
                      input logic [127:0] dst, input logic [63:0] exp_lo,
                      input logic exp_inx, input string req);
    exp_t e;
    @(negedge clk);
    in_vld   = 1'b1;
    in_src   = src;
    in_is64  = is64;
    in_rmode = rm;
    in_dst   = dst;
    e.dst = {dst[127:64], exp_lo};
    e.inx = exp_inx;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic send_ref(input logic [63:0] src, input logic is64, input logic [1:0] rm,
                          input logic [127:0] dst, input string req);
    logic [64:0] r;
    r = ref_conv(src, is64, rm);
    send(src, is64, rm, dst, r[63:0], r[64], req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
    in_src = $urandom();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1: out_vld=1 with no pending operation (expected 0)");
      end else begin
        e = sb.pop_front();
        if (out_dst !== e.dst || out_inexact !== e.inx) begin
          errors++;
          $display("FAIL %s: got dst=%h inx=%b expected dst=%h inx=%b",
                   e.req, out_dst, out_inexact, e.dst, e.inx);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    finish_run();
  end

  initial begin
    logic [127:0] d;
    in_vld = 1'b0; in_is64 = 1'b0; in_rmode = 2'b00; in_src = '0; in_dst = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    in_vld = 1'b1;  // must be ignored while in reset
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_vld during reset got %b expected 0", out_vld);
    end
    in_vld = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_vld after reset got %b expected 0", out_vld);
    end

    d = {64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444};
    // R3 exact values
    send(64'd1, 1'b1, 2'b00, d, 64'h3FF0_0000_0000_0000, 1'b0, "R3");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b00, d, 64'hBFF0_0000_0000_0000, 1'b0, "R3");
    idle();
    // R6 most negative
    send(64'h8000_0000_0000_0000, 1'b1, 2'b11, d, 64'hC3E0_0000_0000_0000, 1'b0, "R6");
    // R5 zero in all modes
    for (int m = 0; m < 4; m++)
      send(64'd0, 1'b1, m[1:0], d, 64'd0, 1'b0, "R5");
    send(64'hFFFF_FFFF_0000_0000, 1'b0, 2'b10, d, 64'd0, 1'b0, "R5");
    // R2 narrow: upper source bits ignored
    send(64'hDEAD_BEEF_FFFF_FFFF, 1'b0, 2'b00, d, 64'hBFF0_0000_0000_0000, 1'b0, "R2");
    send(64'h1234_5678_8000_0000, 1'b0, 2'b01, d, 64'hC1E0_0000_0000_0000, 1'b0, "R2");
    // 2^53+1: tie
    send(64'h0020_0000_0000_0001, 1'b1, 2'b00, d, 64'h4340_0000_0000_0000, 1'b1, "R7");
    send(64'h0020_0000_0000_0003, 1'b1, 2'b00, d, 64'h4340_0000_0000_0002, 1'b1, "R7");
    send(64'h0020_0000_0000_0001, 1'b1, 2'b10, d, 64'h4340_0000_0000_0001, 1'b1, "R9");
    send(64'h0020_0000_0000_0001, 1'b1, 2'b01, d, 64'h4340_0000_0000_0000, 1'b1, "R8");
    send(64'hFFDF_FFFF_FFFF_FFFF, 1'b1, 2'b01, d, 64'hC340_0000_0000_0001, 1'b1, "R8");
    send(64'hFFDF_FFFF_FFFF_FFFF, 1'b1, 2'b10, d, 64'hC340_0000_0000_0000, 1'b1, "R9");
    send(64'hFFDF_FFFF_FFFF_FFFF, 1'b1, 2'b11, d, 64'hC340_0000_0000_0000, 1'b1, "R10");
    // R12 carry cases, R11 inexact
    send(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 2'b00, d, 64'h43E0_0000_0000_0000, 1'b1, "R12");
    send(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 2'b11, d, 64'h43DF_FFFF_FFFF_FFFF, 1'b1, "R10");
    send(64'h8000_0000_0000_0001, 1'b1, 2'b01, d, 64'hC3E0_0000_0000_0000, 1'b1, "R12");
    send(64'h8000_0000_0000_0001, 1'b1, 2'b10, d, 64'hC3DF_FFFF_FFFF_FFFF, 1'b1, "R11");
    idle();
    idle();
    // R4 with varied upper halves, plus random coverage of all modes
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s;
      s = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: s = s >> $urandom_range(0, 63);
        1: s = s | 64'h0000_0000_0000_07FF;
        default: ;
      endcase
      send_ref(s, 1'($urandom()), 2'($urandom()), {$urandom(), $urandom(), $urandom(), $urandom()},
               "R4 R11 random");
      if ($urandom_range(0, 7) == 0) idle();
    end
    repeat (4) idle();
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing (expected 0)", sb.size());
    end
    finish_run();
  end
endmodule